// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host port and an external 16-bit asynchronous static RAM with 17 address bits and independent byte-lane enables. A host presents one access at a time on a request/ready handshake. The access is a read or a write with an address, write data and a two-bit lane mask. The controller then walks the memory's active-low strobes through a fixed sequence of phases and signals completion with a single-cycle done pulse. For a read, the captured word is presented alongside that pulse.

Every phase length is a cycle count computed at elaboration from a clock-period parameter and a set of nanosecond minimums. Each count is the ceiling of time over period, with a floor of one cycle. A write is sequenced as an address setup phase, a turnaround phase with write-enable low and the bus undriven, a data phase that drives the bus, and a hold phase after write-enable rises. The data and hold phases are lengthened as needed so that the pulse-width, chip-select-to-end and full-cycle minimums are all met. A read holds chip-select and output-enable low for the access time and captures on its last cycle. A recovery phase then follows, which gives the memory time to release the bus before the next access.

The data bus is split into a separate output, output-enable and input. The tri-state pad lives outside this block.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, ready_o is 1, done_o is 0, sram_ce_n_o, sram_oe_n_o and sram_we_n_o are 1, sram_be_n_o is all ones and sram_dq_oe_o is 0.
- R2: A request is taken only on a clock edge where req_i and ready_o are both 1. ready_o stays 0 from that edge until the access and any recovery have finished.
- R3: In a write, sram_we_n_o is low only while sram_ce_n_o is low. It stays low for at least ceil(50/CLK_NS) cycles. Chip-select is low for at least ceil(60/CLK_NS) cycles up to the rise of write-enable, and for at least ceil(70/CLK_NS) cycles in total.
- R4: Write data is driven for at least ceil(30/CLK_NS) consecutive cycles before write-enable rises. It is still driven, unchanged, in the cycle after the rise.
- R5: sram_dq_oe_o is 1 only in the write data and hold phases. It is never 1 while sram_oe_n_o is 0. Write-enable has been low for at least ceil(25/CLK_NS) cycles before the bus is first driven.
- R6: sram_oe_n_o and sram_we_n_o are never low together. A read never lowers write-enable.
- R7: In a read, chip-select and output-enable are low for exactly max(ceil(70/CLK_NS), ceil(35/CLK_NS)) cycles. The data present on sram_dq_i in the last of those cycles is what is returned.
- R8: mask bit 1 selects the high lane (bits 15:8) and drives sram_be_n_o[1] low. Mask bit 0 selects the low lane (bits 7:0) and drives sram_be_n_o[0] low. A write changes only the selected lanes, and a write with mask 00 changes nothing.
- R9: In returned read data, a lane whose mask bit is 0 reads as zero.
- R10: done_o is a one-cycle pulse in the cycle after an access's last strobe phase. rdata_o holds the read word from that cycle on.
- R11: After a read, ready_o stays 0 for at least ceil(25/CLK_NS) cycles counted from the done pulse. The bus is never driven while the memory may still be driving it.
- R12: sram_addr_o is stable for as long as sram_ce_n_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data |
| mask_i | input | 2 | Lane select, bit 1 high lane, bit 0 low lane |
| ready_o | output | 1 | Controller idle, request may be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, unselected lanes zero |
| sram_addr_o | output | 17 | Memory address |
| sram_dq_o | output | 16 | Data toward memory |
| sram_dq_oe_o | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | 16 | Data from memory |
| sram_ce_n_o | output | 1 | Chip select, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_be_n_o | output | 2 | Lane enables, active low, bit 1 high lane |

## Verification
The assertions check on every cycle the relations that hold between strobes. Output-enable and write-enable are never low together, and the bus is never driven while output-enable is low. Write-enable falls only under chip-select, the address does not move under chip-select, and done lasts one cycle. Phase lengths, data setup before the write-ending edge and the turnaround gap cannot be seen within one cycle. They, together with lane masking and the read capture instant, are shown only by the bench's memory model. That model measures each strobe interval and returns garbage until the access time has elapsed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_W_SETUP,
    S_W_TURN,
    S_W_DATA,
    S_W_HOLD,
    S_R_ACC,
    S_R_REC
  } state_e;

  // ceiling of ns/period, never below one cycle
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int NB     = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [NB-1:0]     lane_en_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int LW = DATA_W / NB;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lane_q <= '0;
      else if (cap_i) lane_q <= lane_en_i[g] ? dq_i[g*LW +: LW] : '0;
    end
    assign rdata_o[g*LW +: LW] = lane_q;
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 5,
  parameter int T_SA_NS  = 0,
  parameter int T_HZ_NS  = 25,
  parameter int T_SD_NS  = 30,
  parameter int T_WP_NS  = 50,
  parameter int T_SCE_NS = 60,
  parameter int T_WC_NS  = 70,
  parameter int T_RC_NS  = 70,
  parameter int T_OE_NS  = 35
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        mask_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_ce_n_o,
  output logic              sram_oe_n_o,
  output logic              sram_we_n_o,
  output logic [1:0]        sram_be_n_o
);

  localparam int NB      = 2;
  localparam int SETUP_C = ns2cyc(T_SA_NS, CLK_NS);
  localparam int TURN_C  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int DATA_C  = imax(imax(ns2cyc(T_SD_NS, CLK_NS), ns2cyc(T_WP_NS, CLK_NS) - TURN_C),
                                imax(ns2cyc(T_SCE_NS, CLK_NS) - SETUP_C - TURN_C, 1));
  localparam int HOLD_C  = imax(ns2cyc(T_WC_NS, CLK_NS) - SETUP_C - TURN_C - DATA_C, 1);
  localparam int ACC_C   = imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS));
  localparam int REC_C   = TURN_C;
  localparam int MAX_C   = imax(imax(imax(SETUP_C, TURN_C), imax(DATA_C, HOLD_C)), ACC_C);
  localparam int CNT_W   = $clog2(MAX_C + 1);

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [NB-1:0]     mask_q;
  logic              done_q;
  logic              ph_zero;
  logic              ph_load;
  logic [CNT_W-1:0]  ph_val;
  logic              take;
  logic              rd_cap;

  assign take = req_i && (state_q == S_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (req_i) state_d = we_i ? S_W_SETUP : S_R_ACC;
      S_W_SETUP: if (ph_zero) state_d = S_W_TURN;
      S_W_TURN:  if (ph_zero) state_d = S_W_DATA;
      S_W_DATA:  if (ph_zero) state_d = S_W_HOLD;
      S_W_HOLD:  if (ph_zero) state_d = S_IDLE;
      S_R_ACC:   if (ph_zero) state_d = S_R_REC;
      S_R_REC:   if (ph_zero) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      S_W_SETUP: ph_val = CNT_W'(SETUP_C - 1);
      S_W_TURN:  ph_val = CNT_W'(TURN_C - 1);
      S_W_DATA:  ph_val = CNT_W'(DATA_C - 1);
      S_W_HOLD:  ph_val = CNT_W'(HOLD_C - 1);
      S_R_ACC:   ph_val = CNT_W'(ACC_C - 1);
      S_R_REC:   ph_val = CNT_W'(REC_C - 1);
      default:   ph_val = '0;
    endcase
  end

  assign ph_load = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= ph_zero && ((state_q == S_W_HOLD) || (state_q == S_R_ACC));
      if (take) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        mask_q  <= mask_i;
      end
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ph_load),
    .val_i  (ph_val),
    .zero_o (ph_zero)
  );

  assign rd_cap = (state_q == S_R_ACC) && ph_zero;

  sram_rd_capture #(.NB(NB), .DATA_W(DATA_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (rd_cap),
    .lane_en_i (mask_q),
    .dq_i      (sram_dq_i),
    .rdata_o   (rdata_o)
  );

  logic sel;
  assign sel          = (state_q != S_IDLE) && (state_q != S_R_REC);
  assign ready_o      = (state_q == S_IDLE);
  assign done_o       = done_q;
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign sram_ce_n_o  = !sel;
  assign sram_oe_n_o  = (state_q != S_R_ACC);
  assign sram_we_n_o  = !((state_q == S_W_TURN) || (state_q == S_W_DATA));
  assign sram_be_n_o  = sel ? ~mask_q : '1;
  assign sram_dq_oe_o = (state_q == S_W_DATA) || (state_q == S_W_HOLD);

  // R6
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_n_o && !sram_we_n_o));

  // R5
  no_drive_under_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_n_o);

  // R3
  we_under_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_n_o) |-> !sram_ce_n_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_n_o && $past(!sram_ce_n_o)) |-> $stable(sram_addr_o));

  // R2
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i) |=> !ready_o);

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

  localparam int CLK_NS = 5;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_C = (cyc(70) > cyc(35)) ? cyc(70) : cyc(35);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  mask = '0;
  logic        ready, done;
  logic [15:0] rdata;
  logic [16:0] m_addr;
  logic [15:0] m_dq_o;
  logic        m_dq_oe;
  logic [15:0] m_dq_i = 16'hDEAD;
  logic        ce_n, oe_n, we_n;
  logic [1:0]  be_n;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .mask_i(mask), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .sram_addr_o(m_addr), .sram_dq_o(m_dq_o), .sram_dq_oe_o(m_dq_oe), .sram_dq_i(m_dq_i),
    .sram_ce_n_o(ce_n), .sram_oe_n_o(oe_n), .sram_we_n_o(we_n), .sram_be_n_o(be_n)
  );

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic check_ge(input string req_tag, input int act, input int lo);
    n_chk++;
    if (act < lo) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected >= %0d", req_tag, act, lo);
    end
  endtask

  // ---------------- memory model, sampled at negedge ----------------
  logic [15:0] mem [int];
  logic        p_wr = 1'b0, p_ce = 1'b0;
  logic [15:0] p_dq = '0;
  logic [1:0]  p_be_n = 2'b11;
  logic [16:0] p_addr = '0;
  int we_cnt = 0, drv_cnt = 0, turn_cnt = 0, ce_cnt = 0, rd_cnt = 0, rel_cnt = 99;
  int last_we = 0, last_drv = 0, last_turn = 0, last_sce = 0, last_ce = 0, last_rd = 0;
  int contention = 0;
  logic seen_drv = 1'b0;
  logic hold_ok = 1'b0;

  function automatic logic [15:0] rd_word(input logic [16:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic wr_now, ce_now, rd_now;
    wr_now = !ce_n && !we_n;
    ce_now = !ce_n;
    rd_now = !ce_n && !oe_n && we_n;
    // memory may be driving: read active or release window
    if (m_dq_oe && (rd_now || rel_cnt < cyc(25))) contention++;
    if (wr_now) begin
      we_cnt++;
      if (m_dq_oe) begin
        if (!seen_drv) turn_cnt = we_cnt - 1;
        seen_drv = 1'b1;
        drv_cnt++;
      end else drv_cnt = 0;
    end
    if (ce_now) ce_cnt++;
    if (p_wr && !wr_now) begin
      last_we   = we_cnt;
      last_drv  = drv_cnt;
      last_turn = turn_cnt;
      last_sce  = ce_cnt - (ce_now ? 1 : 0);
      hold_ok   = m_dq_oe && (m_dq_o == p_dq);
      begin
        logic [15:0] w;
        w = rd_word(p_addr);
        if (!p_be_n[0]) w[7:0]  = p_dq[7:0];
        if (!p_be_n[1]) w[15:8] = p_dq[15:8];
        mem[int'(p_addr)] = w;
      end
      we_cnt = 0; drv_cnt = 0; seen_drv = 1'b0;
    end
    if (p_ce && !ce_now) begin
      last_ce = ce_cnt;
      ce_cnt  = 0;
    end
    if (rd_now) begin
      if (rd_cnt > 0 && m_addr != p_addr) rd_cnt = 1;
      else rd_cnt++;
      rel_cnt = 0;
    end else begin
      if (rd_cnt > 0) last_rd = rd_cnt;
      rd_cnt = 0;
      if (rel_cnt < 99) rel_cnt++;
    end
    if (rd_cnt >= RD_C) begin
      logic [15:0] d;
      d = rd_word(m_addr);
      m_dq_i <= {be_n[1] ? 8'hA5 : d[15:8], be_n[0] ? 8'h5A : d[7:0]};
    end else m_dq_i <= 16'hDEAD;
    p_wr = wr_now; p_ce = ce_now; p_dq = m_dq_o; p_be_n = be_n; p_addr = m_addr;
  end

  // ---------------- access task ----------------
  task automatic access(input logic w, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] r);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; mask = m;
    @(negedge clk);
    req = 1'b0;
    check("R2 ready low after take", {31'd0, ready}, 32'd0);
    while (!done) @(negedge clk);
    r = rdata;
    @(negedge clk);
    check("R10 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 ready", {31'd0, ready}, 32'd1);
    check("R1 strobes", {28'd0, ce_n, oe_n, we_n, m_dq_oe}, {28'd0, 4'b1110});
    check("R1 be_n/done", {29'd0, be_n, done}, {29'd0, 3'b110});
  endtask

  task automatic t_write_timing;
    logic [15:0] r;
    access(1'b1, 17'h00000, 16'h1234, 2'b11, r);
    check_ge("R3 we low", last_we, cyc(50));
    check_ge("R3 ce to write end", last_sce, cyc(60));
    check_ge("R3 write cycle", last_ce, cyc(70));
    check_ge("R4 data setup", last_drv, cyc(30));
    check("R4 hold drive", {31'd0, hold_ok}, 32'd1);
    check_ge("R5 turnaround", last_turn, cyc(25));
  endtask

  task automatic t_read_full;
    logic [15:0] r;
    access(1'b0, 17'h00000, 16'h0, 2'b11, r);
    check("R7 read data", {16'd0, r}, {16'd0, 16'h1234});
    check("R7 access cycles", last_rd, RD_C);
  endtask

  task automatic t_lanes;
    logic [15:0] r;
    access(1'b1, 17'h1FFFF, 16'hAABB, 2'b11, r);
    access(1'b1, 17'h1FFFF, 16'h11CC, 2'b01, r);
    access(1'b0, 17'h1FFFF, 16'h0, 2'b11, r);
    check("R8 low lane write", {16'd0, r}, {16'd0, 16'hAACC});
    access(1'b1, 17'h1FFFF, 16'hEE22, 2'b10, r);
    access(1'b0, 17'h1FFFF, 16'h0, 2'b11, r);
    check("R8 high lane write", {16'd0, r}, {16'd0, 16'hEECC});
    access(1'b1, 17'h1FFFF, 16'h0000, 2'b00, r);
    access(1'b0, 17'h1FFFF, 16'h0, 2'b11, r);
    check("R8 mask 00 no effect", {16'd0, r}, {16'd0, 16'hEECC});
  endtask

  task automatic t_read_mask;
    logic [15:0] r;
    access(1'b0, 17'h1FFFF, 16'h0, 2'b01, r);
    check("R9 high lane zero", {16'd0, r}, {16'd0, 16'h00CC});
    access(1'b0, 17'h1FFFF, 16'h0, 2'b10, r);
    check("R9 low lane zero", {16'd0, r}, {16'd0, 16'hEE00});
  endtask

  task automatic t_read_then_write;
    int n;
    logic [15:0] r;
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 17'h00000; mask = 2'b11;
    @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    check("R10 rdata at done", {16'd0, rdata}, {16'd0, 16'h1234});
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
    check_ge("R11 recovery", n, cyc(25));
    access(1'b1, 17'h00055, 16'h5555, 2'b11, r);
    access(1'b0, 17'h00055, 16'h0, 2'b11, r);
    check("R11 write after read", {16'd0, r}, {16'd0, 16'h5555});
    check("R11 R5 no contention", contention, 0);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected < 100000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_timing();
    t_read_full();
    t_lanes();
    t_read_mask();
    t_read_then_write();
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule